// File: doc/BRIEF.md
# MDIO Management Master with PHY Reset Polling

This block is the management-bus master for an external Ethernet PHY. It generates the MDC clock and drives the MDIO data line through a separate output value and output enable, so a pad cell outside the block can form the tri-state line. On a host request it runs one clause-22 register access, read or write, to a chosen PHY and register. The timing of each bit comes from a wait count given as a parameter.

The block also has a built-in PHY reset sequence. It writes the control register with its self-clearing reset bit set. It then reads the control register again and again until that bit reads back as zero. If the bit is still set after a configured number of reads, the sequence stops and reports a timeout.

The host starts each operation with a one-clock start strobe. It watches busy, and it picks up the result when the one-clock done pulse arrives.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted, and whenever busy is low, mdc is low and mdioOe is low. Busy, done and timeout are low after reset.
- R2: Every frame starts with 32 driven one bits. These are followed, all MSB first, by the start code 01, the opcode (10 for a read, 01 for a write), the 5-bit PHY address and the 5-bit register address.
- R3: On a write (op = 01), the turnaround bits are driven as 10. The 16 data bits follow MSB first. The line is then released (mdioOe low) for one idle bit.
- R4: On a read (op = 00), mdioOe stays low from the first turnaround bit through the idle bit. The 16 data bits are sampled MSB first on rising MDC edges, and the word appears on rdData when done pulses.
- R5: Each MDC half-period lasts WAIT_CNT system clocks. mdioOut and mdioOe change only while mdc is low, that is, at or after a falling MDC edge.
- R6: When op[1] = 1, the block writes register 0 with 16'h8000. It then reads register 0 until bit 15 reads 0, and finishes with done high, timeout low, and rdData equal to the last word read.
- R7: If POLL_LIMIT reads of register 0 all return bit 15 set, the block asserts done with timeout high. rdData then holds the last word read. Timeout stays high until the next accepted start.
- R8: A start strobe that arrives while busy is high is ignored. It sends no frame and does not change the transaction in progress.
- R9: Done is high for exactly one clock at the end of each operation, and busy is low in that clock. rdData holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request strobe, taken only while busy is low |
| op | input | 2 | 00 read, 01 write, 1x PHY reset sequence |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address (not used by the reset sequence) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Last read word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end-of-operation pulse |
| timeout | output | 1 | Reset sequence ran out of polls |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input from the pad |

## Verification
The bench builds the block with WAIT_CNT = 2, so one MDC bit lasts four system clocks and a whole frame takes 260 clocks. This lets the bench measure each half-period directly and run many frames.

POLL_LIMIT is set to 4, so the timeout path is reached within five frames. The bench's PHY model holds its reset bit for a chosen number of reads, and it is set to 0, 2 and 10 reads. This covers three cases: the first poll succeeds, the bit clears part way through polling, and polling runs out.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_LEN    = 32;
  localparam int HDR_LEN    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_START = HDR_LEN + 2;
  localparam int FRAME_LEN  = DATA_START + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_LEN + 1);
  localparam int RESET_BIT  = DATA_W - 1;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
  localparam logic [1:0] TA_REL   = 2'b11;

  localparam logic [ADDR_W-1:0] CTRL_REG   = '0;
  localparam logic [DATA_W-1:0] RESET_WORD = DATA_W'(1) << RESET_BIT;

  typedef struct packed {
    logic              launch;
    logic              rdOp;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regA;
    logic [DATA_W-1:0] data;
  } dpCmd_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_XFER,
    S_RSTW,
    S_RSTR
  } ctlState_t;

  function automatic logic bitDriven(input logic [IDX_W-1:0] idx, input logic rd);
    return rd ? (idx < IDX_W'(HDR_LEN)) : (idx < IDX_W'(FRAME_LEN));
  endfunction

endpackage

// File: rtl/mdio_datapath.sv
`timescale 1ns/1ps
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int WAIT_CNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              frameDone,
  output logic [DATA_W-1:0] rxWord
);

  logic                 active;
  logic                 isRd;
  logic                 phaseEnd;
  logic                 sampleNow;
  logic [IDX_W-1:0]     bitIdx;
  logic [IDX_W-1:0]     nextIdx;
  logic [FRAME_LEN-1:0] txShift;
  logic [FRAME_LEN-1:0] txLoad;

  // Half-period timer: bypassed entirely when one clock per phase is asked for
  generate
    if (WAIT_CNT == 1) begin : g_nodiv
      assign phaseEnd = active;
    end else begin : g_div
      localparam int PH_W = $clog2(WAIT_CNT);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(WAIT_CNT - 1);
      logic [PH_W-1:0] phaseCnt;
      assign phaseEnd = active && (phaseCnt == PH_LAST);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          phaseCnt <= '0;
        else if (!active)   phaseCnt <= '0;
        else if (phaseEnd)  phaseCnt <= '0;
        else                phaseCnt <= phaseCnt + 1'b1;
      end
    end
  endgenerate

  assign nextIdx   = bitIdx + 1'b1;
  assign sampleNow = isRd && (bitIdx >= IDX_W'(DATA_START)) && (bitIdx < IDX_W'(FRAME_LEN));
  assign txLoad    = {{PRE_LEN{1'b1}}, SOF_CODE, (cmd.rdOp ? OP_RD : OP_WR),
                      cmd.phy, cmd.regA, (cmd.rdOp ? TA_REL : TA_WR),
                      (cmd.rdOp ? {DATA_W{1'b0}} : cmd.data)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      isRd      <= 1'b0;
      bitIdx    <= '0;
      mdc       <= 1'b0;
      mdioOut   <= 1'b0;
      mdioOe    <= 1'b0;
      frameDone <= 1'b0;
      txShift   <= '0;
      rxWord    <= '0;
    end else begin
      frameDone <= 1'b0;
      if (cmd.launch && !active) begin
        active  <= 1'b1;
        isRd    <= cmd.rdOp;
        bitIdx  <= '0;
        mdc     <= 1'b0;
        txShift <= txLoad;
        mdioOut <= txLoad[FRAME_LEN-1];
        mdioOe  <= 1'b1;
      end else if (phaseEnd) begin
        if (!mdc) begin
          mdc <= 1'b1;
          if (sampleNow) rxWord <= {rxWord[DATA_W-2:0], mdioIn};
        end else begin
          mdc <= 1'b0;
          if (bitIdx == IDX_W'(FRAME_LEN)) begin
            active    <= 1'b0;
            frameDone <= 1'b1;
          end else begin
            bitIdx  <= nextIdx;
            txShift <= {txShift[FRAME_LEN-2:0], 1'b0};
            if (bitDriven(nextIdx, isRd)) begin
              mdioOe  <= 1'b1;
              mdioOut <= txShift[FRAME_LEN-2];
            end else begin
              mdioOe  <= 1'b0;
              mdioOut <= 1'b0;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] rxWord,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              timeout
);

  localparam int PC_W = $clog2(POLL_LIMIT) + 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(POLL_LIMIT);

  ctlState_t       state;
  logic [PC_W-1:0] pollCnt;
  logic [PC_W-1:0] pollNext;

  assign busy     = (state != S_IDLE);
  assign pollNext = pollCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cmd     <= '0;
      pollCnt <= '0;
      rdData  <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      cmd.launch <= 1'b0;
      done       <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          timeout    <= 1'b0;
          cmd.launch <= 1'b1;
          cmd.phy    <= phyAddr;
          if (op[1]) begin
            cmd.rdOp <= 1'b0;
            cmd.regA <= CTRL_REG;
            cmd.data <= RESET_WORD;
            state    <= S_RSTW;
          end else begin
            cmd.rdOp <= ~op[0];
            cmd.regA <= regAddr;
            cmd.data <= wrData;
            state    <= S_XFER;
          end
        end
        S_XFER: if (frameDone) begin
          if (cmd.rdOp) rdData <= rxWord;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_RSTW: if (frameDone) begin
          cmd.launch <= 1'b1;
          cmd.rdOp   <= 1'b1;
          pollCnt    <= '0;
          state      <= S_RSTR;
        end
        S_RSTR: if (frameDone) begin
          pollCnt <= pollNext;
          if (!rxWord[RESET_BIT]) begin
            rdData <= rxWord;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else if (pollNext == PC_LAST) begin
            rdData  <= rxWord;
            done    <= 1'b1;
            timeout <= 1'b1;
            state   <= S_IDLE;
          end else begin
            cmd.launch <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int          WAIT_CNT   = 8,
  parameter int unsigned POLL_LIMIT = 32'h0002_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        busy,
  output logic        done,
  output logic        timeout,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  dpCmd_t            dpCmd;
  logic              frameDone;
  logic [DATA_W-1:0] rxWord;

  mdio_ctrl #(.POLL_LIMIT(POLL_LIMIT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .op        (op),
    .phyAddr   (phyAddr),
    .regAddr   (regAddr),
    .wrData    (wrData),
    .frameDone (frameDone),
    .rxWord    (rxWord),
    .cmd       (dpCmd),
    .rdData    (rdData),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout)
  );

  mdio_datapath #(.WAIT_CNT(WAIT_CNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (dpCmd),
    .mdioIn    (mdioIn),
    .mdc       (mdc),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe),
    .frameDone (frameDone),
    .rxWord    (rxWord)
  );

endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        timeout,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic [15:0] rdData
);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  p_out_on_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> !mdc);

  p_oe_on_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOe) |-> !mdc);

  p_timeout_at_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeout) |-> done);

  p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(rdData));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .timeout (timeout),
  .mdc     (mdc),
  .mdioOut (mdioOut),
  .mdioOe  (mdioOe),
  .rdData  (rdData)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;

  localparam int WAIT = 2;
  localparam int LIMIT = 4;
  localparam logic [1:0] OPC_RD = 2'b00, OPC_WR = 2'b01, OPC_RST = 2'b10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, mdioIn = 1'b1;
  logic [1:0] op = '0;
  logic [4:0] phyAddr = '0, regAddr = '0;
  logic [15:0] wrData = '0, rdData;
  logic busy, done, timeout, mdc, mdioOut, mdioOe;

  always #5 clk = ~clk;

  mdio_master #(.WAIT_CNT(WAIT), .POLL_LIMIT(LIMIT)) i_mdio_master (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .phyAddr(phyAddr),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .busy(busy),
    .done(done), .timeout(timeout), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nChk = 0, nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- PHY model ----------------
  logic [15:0] mem [0:1023];
  int resetCfg = 0, resetLeft = 0, frameCnt = 0, protoErr = 0;
  int mState = 0, preCnt = 0, hCnt = 0, rCnt = 0, wCnt = 0, nIdx = 0;
  logic [11:0] hdr;
  logic [17:0] wShift;
  logic [15:0] respWord;
  logic [1:0] lastOp, lastTa;
  logic [4:0] lastPhy, lastReg;
  logic [15:0] lastData;

  function automatic logic [15:0] initVal(input int i);
    return 16'(i * 257 + 16'h0300);
  endfunction

  always @(posedge mdc) begin
    case (mState)
      0: begin
        if (mdioOe && mdioOut) preCnt++;
        else if (mdioOe && !mdioOut) begin
          if (preCnt != 32) protoErr++;
          mState = 1;
        end else preCnt = 0;
      end
      1: begin
        if (!(mdioOe && mdioOut)) protoErr++;
        mState = 2; hCnt = 0; hdr = '0;
      end
      2: begin
        if (!mdioOe) protoErr++;
        hdr = {hdr[10:0], mdioOut};
        hCnt++;
        if (hCnt == 12) begin
          lastOp = hdr[11:10]; lastPhy = hdr[9:5]; lastReg = hdr[4:0]; preCnt = 0;
          if (hdr[11:10] == 2'b10) begin
            if (lastReg == 5'd0 && resetLeft > 0) begin
              resetLeft--;
              respWord = mem[{lastPhy, lastReg}] | 16'h8000;
            end else respWord = mem[{lastPhy, lastReg}];
            nIdx = 0; rCnt = 0; mState = 3;
          end else begin
            wCnt = 0; wShift = '0; mState = 4;
          end
        end
      end
      3: begin
        if (mdioOe) protoErr++;
        rCnt++;
        if (rCnt == 19) begin frameCnt++; mState = 0; end
      end
      4: begin
        if (!mdioOe) protoErr++;
        wShift = {wShift[16:0], mdioOut};
        wCnt++;
        if (wCnt == 18) begin
          lastTa = wShift[17:16]; lastData = wShift[15:0];
          if (lastReg == 5'd0 && lastData[15]) begin
            mem[{lastPhy, lastReg}] = 16'h1140;
            resetLeft = resetCfg;
          end else mem[{lastPhy, lastReg}] = lastData;
          mState = 5;
        end
      end
      default: begin
        if (mdioOe) protoErr++;
        frameCnt++; mState = 0;
      end
    endcase
  end

  always @(negedge mdc) begin
    if (mState == 3) begin
      if (nIdx == 0) mdioIn = 1'b1;
      else if (nIdx == 1) mdioIn = 1'b0;
      else if (nIdx <= 17) mdioIn = respWord[17 - nIdx];
      else mdioIn = 1'b1;
      nIdx++;
    end else mdioIn = 1'b1;
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic chkRd; logic [15:0] rd; logic to; logic [7:0] frames; } exp_t;
  exp_t expQ[$];
  string tagQ[$];
  int pushCnt = 0, popCnt = 0;
  logic prevDone = 1'b0;

  always @(negedge clk) begin
    if (prevDone) check(!done, "R9", "done wider than one clock", done, 0);
    prevDone = done;
    if (done) begin
      exp_t e;
      string t;
      if (expQ.size() == 0) check(0, "R8", "unexpected done", 1, 0);
      else begin
        e = expQ.pop_front(); t = tagQ.pop_front();
        if (e.chkRd) check(rdData == e.rd, t, "rdData", rdData, e.rd);
        check(timeout == e.to, t, "timeout", timeout, e.to);
        check(frameCnt == int'(e.frames), t, "frame count", frameCnt, e.frames);
        check(!busy, "R9", "busy at done", busy, 0);
      end
      popCnt++;
    end
  end

  task automatic kick(input logic [1:0] o, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] d, input bit chkRd, input logic [15:0] expRd,
                      input bit expTo, input int frames, input string tag);
    expQ.push_back({chkRd, expRd, expTo, 8'(frames)});
    tagQ.push_back(tag);
    pushCnt++;
    @(negedge clk);
    frameCnt = 0;
    op = o; phyAddr = p; regAddr = r; wrData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (popCnt < pushCnt) @(negedge clk);
  endtask

  task automatic runOp(input logic [1:0] o, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, input bit chkRd, input logic [15:0] expRd,
                       input bit expTo, input int frames, input string tag);
    kick(o, p, r, d, chkRd, expRd, expTo, frames, tag);
    waitDone();
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R9", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    longint t1, t2, t3;
    for (int i = 0; i < 1024; i++) mem[i] = initVal(i);
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !timeout, "R1", "status in reset", {busy, done, timeout}, 0);
    check(!mdc && !mdioOe, "R1", "mdc/mdioOe in reset", {mdc, mdioOe}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3: write frame layout
    runOp(OPC_WR, 5'd7, 5'd5, 16'hA5C3, 0, 0, 0, 1, "R3");
    check(lastOp == 2'b01, "R2", "write opcode", lastOp, 2'b01);
    check(lastPhy == 5'd7, "R2", "phy address", lastPhy, 7);
    check(lastReg == 5'd5, "R2", "register address", lastReg, 5);
    check(lastTa == 2'b10, "R3", "write turnaround", lastTa, 2'b10);
    check(lastData == 16'hA5C3, "R3", "write data", lastData, 16'hA5C3);
    check(protoErr == 0, "R3", "frame errors on write", protoErr, 0);

    // R4: reads
    runOp(OPC_RD, 5'd7, 5'd5, 16'hFFFF, 1, 16'hA5C3, 0, 1, "R4");
    check(lastOp == 2'b10, "R2", "read opcode", lastOp, 2'b10);
    runOp(OPC_RD, 5'd31, 5'd31, 16'h0, 1, initVal(1023), 0, 1, "R4");
    check(lastPhy == 5'd31 && lastReg == 5'd31, "R2", "max addresses", {lastPhy, lastReg}, 10'h3FF);
    runOp(OPC_RD, 5'd0, 5'd18, 16'h0, 1, initVal(18), 0, 1, "R4");
    check(protoErr == 0, "R4", "bus driven during read release", protoErr, 0);

    // R5: MDC half-period
    kick(OPC_RD, 5'd7, 5'd5, 16'h0, 1, 16'hA5C3, 0, 1, "R4");
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    @(negedge mdc); t3 = $time;
    check(t2 - t1 == WAIT * 10, "R5", "mdc low time ns", t2 - t1, WAIT * 10);
    check(t3 - t2 == WAIT * 10, "R5", "mdc high time ns", t3 - t2, WAIT * 10);
    waitDone();

    // R9: rdData held while idle
    repeat (40) @(negedge clk);
    check(rdData == 16'hA5C3, "R9", "rdData held", rdData, 16'hA5C3);

    // R8: start while busy is ignored
    kick(OPC_WR, 5'd7, 5'd9, 16'h1111, 0, 0, 0, 1, "R8");
    repeat (60) @(negedge clk);
    op = OPC_WR; regAddr = 5'd9; wrData = 16'h2222; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    runOp(OPC_RD, 5'd7, 5'd9, 16'h0, 1, 16'h1111, 0, 1, "R8");

    // R6: reset sequence, bit clears on third poll
    resetCfg = 2;
    runOp(OPC_RST, 5'd7, 5'd3, 16'h0, 1, 16'h1140, 0, 4, "R6");
    check(lastReg == 5'd0 && lastOp == 2'b10, "R6", "poll targets register 0", {lastOp, lastReg}, 7'h40);
    // R6: bit already clear on first poll
    resetCfg = 0;
    runOp(2'b11, 5'd7, 5'd3, 16'h0, 1, 16'h1140, 0, 2, "R6");

    // R7: poll budget runs out
    resetCfg = 10;
    runOp(OPC_RST, 5'd7, 5'd0, 16'h0, 1, 16'h9140, 1, 5, "R7");
    repeat (20) @(negedge clk);
    check(timeout == 1'b1, "R7", "timeout sticky", timeout, 1);
    kick(OPC_RD, 5'd7, 5'd5, 16'h0, 1, 16'hA5C3, 0, 1, "R7");
    check(timeout == 1'b0, "R7", "timeout cleared by start", timeout, 0);
    waitDone();
    check(protoErr == 0, "R2", "frame errors overall", protoErr, 0);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule